// File: doc/BRIEF.md
# Memory Test Access Port

This block is the boundary-scan test port of a memory device. A 16-state controller, clocked by the test clock, walks the usual capture, shift, pause and update sequences for an instruction path and a data path. A 3-bit instruction selects one of three data paths: a single bypass cell, a 32-bit identification word, or a boundary chain of `BS_LEN` cells. The boundary cells are modelled as a parallel vector that is sampled in Capture-DR and then shifted out, plus one control output that tells the data pads to float.

There is no dedicated test reset pin. The controller reaches Test-Logic-Reset from the chip's power-on reset (`por_n`), or from any state by holding TMS high. Serial output is launched on the falling edge of the test clock and is enabled only while a shift state is active. Two of the eight opcodes sample the pins with the data pads floated. One opcode samples the pins with the pads left driving. The opcode space also holds the identification opcode and the bypass opcode, and the three remaining codes are reserved. A reserved code keeps the chain intact through the bypass cell.

Top module: `mem_tap`

## Requirements
- R1: While `por_n` is low and after it rises, the controller is in Test-Logic-Reset, the active instruction is 3'b001 (identification), `dq_hiz` is 0 and `tdo_oe` is 0.
- R2: The controller follows the standard 16-state transition graph on TMS, and five consecutive rising edges with TMS high reach Test-Logic-Reset from any state; that state restores instruction 3'b001.
- R3: The instruction register is 3 bits wide and is shifted least significant bit first. Capture-IR loads 3'b001, so the first three bits out are 1, 0, 0. The new instruction takes effect on the rising edge that leaves Update-IR and at no other time.
- R4: Instruction 3'b001 connects the 32-bit identification word, least significant bit first. The word is {revision[31:28], density/configuration[27:18], vendor field[17:12], manufacturer code[11:1], 1'b1}.
- R5: Instructions 3'b000 and 3'b010 connect the boundary chain and drive `dq_hiz` to 1.
- R6: Instruction 3'b100 connects the boundary chain with `dq_hiz` at 0.
- R7: Instruction 3'b111, and the reserved codes 3'b011, 3'b101 and 3'b110, connect the one-bit bypass cell, which loads 0 in Capture-DR, with `dq_hiz` at 0.
- R8: The bypass cell keeps the last TDI bit shifted in when the controller leaves Shift-DR. Re-entering Shift-DR through Pause-DR and Exit2-DR presents that bit on TDO first.
- R9: `tdo` and `tdo_oe` change only on the falling edge of `tck`, and `tdo_oe` is 1 exactly in the half-cycles that follow a falling edge in Shift-IR or Shift-DR.
- R10: In Capture-DR with a boundary instruction, the chain loads `pin_sample`, and bit 0 appears on TDO first. The chain is `BS_LEN` cells long, so TDI reappears on TDO after `BS_LEN` shifts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset from the supply monitor, active low, asynchronous |
| tms | input | 1 | Test mode select, sampled on the rising edge |
| tdi | input | 1 | Serial test data in, sampled on the rising edge |
| pin_sample | input | BS_LEN | Parallel values seen at the boundary cells |
| tdo | output | 1 | Serial test data out, launched on the falling edge |
| tdo_oe | output | 1 | High while `tdo` carries shift data |
| dq_hiz | output | 1 | Forces the data pads to High-Z |

## Verification
The assertions assume that `por_n` is low for at least one rising edge before any TMS activity. They also assume that TMS and TDI settle well clear of the rising edge and that `pin_sample` holds steady across Capture-DR. The stimulus meets these assumptions in three ways. It releases reset on a falling edge after several clock cycles. It changes TMS and TDI only just after a falling edge. It sets the pin vector before each data scan starts. Every opcode is swept. For each one, the bench checks the captured instruction bits and the pad control. It also checks the full scanned-out stream, including the point where TDI reappears after exactly the path length.

// File: rtl/tap_pkg.sv
package tap_pkg;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI, ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR,
    ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {PATH_BYP, PATH_ID, PATH_BND} dr_path_e;

  localparam int IR_W = 3;
  localparam int ID_W = 32;
  localparam logic [IR_W-1:0] OP_FLOAT_A = 3'b000;
  localparam logic [IR_W-1:0] OP_IDENT   = 3'b001;
  localparam logic [IR_W-1:0] OP_FLOAT_B = 3'b010;
  localparam logic [IR_W-1:0] OP_PROBE   = 3'b100;
  localparam logic [IR_W-1:0] OP_PASS    = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    case (s)
      ST_TLR:    return m ? ST_TLR    : ST_RTI;
      ST_RTI:    return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: return m ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
      default:   return m ? ST_SEL_DR : ST_RTI;
    endcase
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       por_n,
  input  logic       tms,
  output tap_state_e state
);

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) state <= ST_TLR;
    else        state <= tap_next(state, tms);
  end

  // Checker: run of TMS-high edges, saturating at five.
  logic [2:0] high_run;
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)            high_run <= 3'd0;
    else if (!tms)         high_run <= 3'd0;
    else if (high_run < 5) high_run <= high_run + 3'd1;
  end

  assert_five_high_reset_R2: assert property (@(posedge tck) disable iff (!por_n)
    (high_run == 3'd5) |-> (state == ST_TLR));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic            tck,
  input  logic            por_n,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_so,
  output dr_path_e        dr_path,
  output logic            dq_hiz
);

  logic [IR_W-1:0] ir_sh;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) ir_sh <= IR_CAPTURE;
    else if (state == ST_CAP_IR) ir_sh <= IR_CAPTURE;
    else if (state == ST_SH_IR)  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) ir_q <= OP_IDENT;
    else if (state == ST_TLR)    ir_q <= OP_IDENT;
    else if (state == ST_UPD_IR) ir_q <= ir_sh;
  end

  assign ir_so = ir_sh[0];

  always_comb begin
    case (ir_q)
      OP_IDENT:               begin dr_path = PATH_ID;  dq_hiz = 1'b0; end
      OP_FLOAT_A, OP_FLOAT_B: begin dr_path = PATH_BND; dq_hiz = 1'b1; end
      OP_PROBE:               begin dr_path = PATH_BND; dq_hiz = 1'b0; end
      default:                begin dr_path = PATH_BYP; dq_hiz = 1'b0; end
    endcase
  end

  assert_reset_selects_ident_R1: assert property (@(posedge tck) disable iff (!por_n)
    (state == ST_TLR) |=> (ir_q == OP_IDENT));

  assert_ir_holds_outside_update_R3: assert property (@(posedge tck) disable iff (!por_n)
    (state != ST_TLR && state != ST_UPD_IR) |=> $stable(ir_q));

endmodule

// File: rtl/tap_shift_reg.sv
module tap_shift_reg #(
  parameter int W = 8
) (
  input  logic         tck,
  input  logic         por_n,
  input  logic         cap_en,
  input  logic         sh_en,
  input  logic         tdi,
  input  logic [W-1:0] cap_val,
  output logic         so
);

  logic [W-1:0] q;

  generate
    if (W == 1) begin : g_single
      always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)      q <= '0;
        else if (cap_en) q <= cap_val;
        else if (sh_en)  q <= tdi;
      end
    end else begin : g_chain
      always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)      q <= '0;
        else if (cap_en) q <= cap_val;
        else if (sh_en)  q <= {tdi, q[W-1:1]};
      end
    end
  endgenerate

  assign so = q[0];

  assert_cells_hold_when_idle_R8: assert property (@(posedge tck) disable iff (!por_n)
    (!cap_en && !sh_en) |=> $stable(q));

endmodule

// File: rtl/mem_tap.sv
module mem_tap
  import tap_pkg::*;
#(
  parameter int          BS_LEN  = 70,
  parameter logic [3:0]  ID_REV  = 4'h2,
  parameter logic [9:0]  ID_DENS = 10'h1A6,
  parameter logic [5:0]  ID_VEND = 6'h15,
  parameter logic [10:0] ID_MFR  = 11'h2B5
) (
  input  logic              tck,
  input  logic              por_n,
  input  logic              tms,
  input  logic              tdi,
  input  logic [BS_LEN-1:0] pin_sample,
  output logic              tdo,
  output logic              tdo_oe,
  output logic              dq_hiz
);

  localparam logic [ID_W-1:0] ID_WORD = {ID_REV, ID_DENS, ID_VEND, ID_MFR, 1'b1};

  tap_state_e      state;
  logic [IR_W-1:0] ir_q;
  logic            ir_so;
  dr_path_e        dr_path;
  logic            byp_so, id_so, bnd_so, dr_so;
  logic            cap_dr, sh_dr;

  tap_fsm u_fsm (.tck(tck), .por_n(por_n), .tms(tms), .state(state));

  tap_ir u_ir (
    .tck(tck), .por_n(por_n), .tdi(tdi), .state(state),
    .ir_q(ir_q), .ir_so(ir_so), .dr_path(dr_path), .dq_hiz(dq_hiz)
  );

  assign cap_dr = (state == ST_CAP_DR);
  assign sh_dr  = (state == ST_SH_DR);

  tap_shift_reg #(.W(1)) u_byp (
    .tck(tck), .por_n(por_n), .cap_en(cap_dr && dr_path == PATH_BYP),
    .sh_en(sh_dr && dr_path == PATH_BYP), .tdi(tdi), .cap_val(1'b0), .so(byp_so)
  );

  tap_shift_reg #(.W(ID_W)) u_id (
    .tck(tck), .por_n(por_n), .cap_en(cap_dr && dr_path == PATH_ID),
    .sh_en(sh_dr && dr_path == PATH_ID), .tdi(tdi), .cap_val(ID_WORD), .so(id_so)
  );

  tap_shift_reg #(.W(BS_LEN)) u_bnd (
    .tck(tck), .por_n(por_n), .cap_en(cap_dr && dr_path == PATH_BND),
    .sh_en(sh_dr && dr_path == PATH_BND), .tdi(tdi), .cap_val(pin_sample), .so(bnd_so)
  );

  always_comb begin
    case (dr_path)
      PATH_ID:  dr_so = id_so;
      PATH_BND: dr_so = bnd_so;
      default:  dr_so = byp_so;
    endcase
  end

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else if (state == ST_SH_IR) begin
      tdo    <= ir_so;
      tdo_oe <= 1'b1;
    end else if (state == ST_SH_DR) begin
      tdo    <= dr_so;
      tdo_oe <= 1'b1;
    end else begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end
  end

  assert_oe_only_in_shift_R9: assert property (@(posedge tck) disable iff (!por_n)
    tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR));

  assert_float_needs_boundary_R5: assert property (@(posedge tck) disable iff (!por_n)
    dq_hiz |-> (dr_path == PATH_BND));

endmodule

// File: tb/mem_tap_tb.sv
module mem_tap_tb;

  localparam int          BS   = 70;
  localparam int          SCAN = 96;
  localparam logic [3:0]  REV  = 4'h9;
  localparam logic [9:0]  DENS = 10'h2C3;
  localparam logic [5:0]  VEND = 6'h2A;
  localparam logic [10:0] MFR  = 11'h4D1;
  localparam logic [31:0] IDW  = {REV, DENS, VEND, MFR, 1'b1};

  logic tck = 1'b0, por_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic [BS-1:0] pins = '0;
  logic tdo, tdo_oe, dq_hiz;
  int tests = 0, fails = 0, edge_err = 0;

  always #2 tck = ~tck;

  mem_tap #(.BS_LEN(BS), .ID_REV(REV), .ID_DENS(DENS), .ID_VEND(VEND), .ID_MFR(MFR)) u_dut (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .pin_sample(pins),
    .tdo(tdo), .tdo_oe(tdo_oe), .dq_hiz(dq_hiz)
  );

  task automatic check(input string req, input logic [SCAN-1:0] act, input logic [SCAN-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called just after a falling edge; returns TDO as seen before the rising edge.
  task automatic step(input logic m, input logic d, output logic o);
    logic oe_pre;
    tms = m; tdi = d; o = tdo; oe_pre = tdo_oe;
    @(posedge tck); #1;
    if (oe_pre && tdo !== o) edge_err++;
    @(negedge tck); #1;
  endtask

  task automatic go(input logic m);
    logic o;
    step(m, 1'b0, o);
  endtask

  task automatic shift_ir(input logic [2:0] op, output logic [2:0] cap);
    logic o;
    go(1); go(1); go(0); go(0);
    for (int i = 0; i < 3; i++) begin step(i == 2, op[i], o); cap[i] = o; end
    go(1); go(0);
  endtask

  task automatic shift_dr(input logic [SCAN-1:0] din, output logic [SCAN-1:0] dout);
    logic o;
    go(1); go(0); go(0);
    for (int i = 0; i < SCAN; i++) begin step(i == SCAN - 1, din[i], o); dout[i] = o; end
    go(1); go(0);
  endtask

  function automatic int path_len(input logic [2:0] op);
    if (op == 3'b001) return 32;
    if (op == 3'b000 || op == 3'b010 || op == 3'b100) return BS;
    return 1;
  endfunction

  function automatic logic [SCAN-1:0] expect_stream(input int len, input logic [SCAN-1:0] cap,
                                                    input logic [SCAN-1:0] din);
    logic [SCAN-1:0] r;
    for (int i = 0; i < SCAN; i++) r[i] = (i < len) ? cap[i] : din[i - len];
    return r;
  endfunction

  initial begin
    #(200000 * 4);
    fails++; tests++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [2:0] cap;
    logic [SCAN-1:0] din, dout, capv;
    logic o;
    repeat (4) @(negedge tck);
    #1;
    check("R1 oe during reset", {95'd0, tdo_oe}, '0);
    por_n = 1'b1;
    @(negedge tck); #1;
    check("R1 dq_hiz after reset", {95'd0, dq_hiz}, '0);
    go(0);
    check("R1 tdo_oe idle", {95'd0, tdo_oe}, '0);
    din = {3{32'hA5C3_0F96}};
    shift_dr(din, dout);
    check("R1 R4 default path is identification", dout, expect_stream(32, {64'd0, IDW}, din));

    // Exhaustive opcode sweep (R3..R7, R10).
    for (int op = 0; op < 8; op++) begin
      for (int b = 0; b < BS; b++) pins[b] = ((b * 7 + op * 3) % 5) < 2;
      shift_ir(op[2:0], cap);
      check($sformatf("R3 captured IR bits op=%0d", op), {93'd0, cap}, {93'd0, 3'b001});
      check($sformatf("R5 R6 R7 dq_hiz op=%0d", op), {95'd0, dq_hiz},
            {95'd0, (op == 0 || op == 2)});
      din = {SCAN{1'b0}};
      for (int i = 0; i < SCAN; i++) din[i] = ((i * 5 + op) % 3) == 0;
      capv = '0;
      if (op == 1) capv[31:0] = IDW;
      else if (path_len(op[2:0]) == BS) capv[BS-1:0] = pins;
      shift_dr(din, dout);
      check($sformatf("R4 R5 R6 R7 R10 scan stream op=%0d", op), dout,
            expect_stream(path_len(op[2:0]), capv, din));
    end

    // R8: bypass cell keeps the last shifted bit through Pause-DR.
    for (int v = 0; v < 2; v++) begin
      shift_ir(3'b111, cap);
      go(1); go(0); go(0);
      step(1, v[0], o);
      go(0); go(0); go(1); go(0);
      step(1, 1'b0, o);
      go(1); go(0);
      check($sformatf("R8 bypass holds %0d", v), {95'd0, o}, {95'd0, v[0]});
    end

    // R2: five TMS-high edges from Pause-IR and from Shift-DR.
    for (int k = 0; k < 2; k++) begin
      shift_ir(3'b010, cap);
      check("R5 float selected before escape", {95'd0, dq_hiz}, {95'd0, 1'b1});
      if (k == 0) begin go(1); go(1); go(0); go(0); go(1); go(0); end
      else begin go(1); go(0); go(0); end
      repeat (5) go(1);
      go(0);
      check($sformatf("R2 five-high escape dq_hiz k=%0d", k), {95'd0, dq_hiz}, '0);
      din = {3{32'h3C5A_9E71}};
      shift_dr(din, dout);
      check($sformatf("R2 escape restores identification k=%0d", k), dout,
            expect_stream(32, {64'd0, IDW}, din));
    end

    check("R9 tdo stable across rising edges while enabled", edge_err, 0);
    check("R9 tdo_oe low in Run-Test-Idle", {95'd0, tdo_oe}, '0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule